// File: doc/BRIEF.md
# Protection Unit Region Configuration Bank

This block is the register bank that software uses to program a memory protection unit. It holds a global control word, a pointer that selects one of a fixed number of regions (at most sixteen, chosen by parameter), and for each region a base address, a size/enable half-word and an access-control half-word. A read-only type word reports how many regions were built. The region base and attribute words can be reached through the primary address pair and through three further alias pairs. Software can then program several regions in a short burst of stores without rewriting the pointer.

Every store that actually changes the protection setup raises a one-cycle invalidate pulse. The pulse tells the translation or lookup logic elsewhere to drop any cached decisions. A store that leaves the control word with the fault-bypass bit set and the enable bit clear is accepted, and it also raises a one-cycle warning pulse. The bank does not check addresses against the regions and does not generate faults.

Register map, byte offsets on `bus_addr`: 0x00 type, 0x04 control, 0x08 region pointer, 0x0C base, 0x10 attribute. The alias pairs sit at 0x14/0x18, 0x1C/0x20 and 0x24/0x28. Any other offset reads zero and ignores stores.

Top module: `mpu_regbank`

## Requirements
- R1: After reset the control, pointer, every base and every attribute read zero, and `prot_enable`, `prot_fault_bypass`, `prot_default_map`, `cfg_invalidate` and `cfg_warn` are low.
- R2: The type word at 0x00 reads the region count shifted left by 8 (0x800 for eight regions). Stores to it change nothing and raise no invalidate.
- R3: The control word keeps only bit 0 (enable, driven on `prot_enable`), bit 1 (fault bypass, on `prot_fault_bypass`) and bit 2 (default map, on `prot_default_map`). Every other bit reads zero.
- R4: A control store with bit 1 set and bit 0 clear is still stored. It raises `cfg_warn` for exactly the cycle after the store; any other control value leaves `cfg_warn` low.
- R5: A pointer store of a value below the region count is stored and reads back. A pointer store at or above the region count is ignored.
- R6: A base store with bit 4 clear writes the region named by the pointer. The address is stored with bits [4:0] cleared. A base read returns the stored address in [31:5], 0 in [4] and the pointer in [3:0].
- R7: A base store with bit 4 set takes the region index from bits [3:0]. It writes that region and also loads the pointer with that index.
- R8: A base store with bit 4 set whose index is at or above the region count is discarded as a whole: the pointer, every base and `cfg_invalidate` are left unchanged.
- R9: An attribute store keeps bits [15:0] masked with 0xFF3F as size/enable and bits [31:16] masked with 0x173F as access control. A read returns access control in [31:16] and size/enable in [15:0].
- R10: The alias pairs at +8, +16 and +24 bytes from the primary pair read and write the same region state as the primary pair.
- R11: `cfg_invalidate` is high in the cycle after each accepted control, base or attribute store, and only then. Pointer, type and unmapped stores do not raise it.
- R12: A store to one region leaves every other region's base and attributes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Store strobe, taken at the rising edge |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from the current state |
| prot_enable | output | 1 | Control bit 0 |
| prot_fault_bypass | output | 1 | Control bit 1 |
| prot_default_map | output | 1 | Control bit 2 |
| cfg_invalidate | output | 1 | One-cycle pulse after a store that changes the configuration |
| cfg_warn | output | 1 | One-cycle pulse after a control store with bypass set and enable clear |

## Verification
Read data has zero latency. Its value reflects every store taken at an earlier edge, so the bench sets the address on the falling edge and compares `bus_rdata` a moment later, within the same cycle. The effect of a store appears one edge after it. `cfg_invalidate` and `cfg_warn` are sampled in the low phase that follows the capturing edge, where they must be high, and again one cycle later, where they must have dropped. Discarded stores are checked through these same pulse samples and then through pointer and base reads on the next cycle.

// File: rtl/mpu_cfg_pkg.sv
package mpu_cfg_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_TYPE, K_CTRL, K_PTR, K_BASE, K_ATTR
  } reg_kind_e;

  localparam logic [7:0] OFF_TYPE  = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h04;
  localparam logic [7:0] OFF_PTR   = 8'h08;
  localparam logic [7:0] OFF_BASE  = 8'h0C;
  localparam int unsigned ALIAS_STEP = 8;

  localparam int unsigned IDX_W  = 4;
  localparam int unsigned BASE_W = 27;
  localparam int unsigned CTRL_W = 3;

  localparam logic [15:0] SIZE_MASK = 16'hFF3F;
  localparam logic [15:0] ACC_MASK  = 16'h173F;

  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_BYPASS = 1;
  localparam int unsigned CB_DEFMAP = 2;
  localparam int unsigned SEL_BIT   = 4;
endpackage

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
  import mpu_cfg_pkg::*;
#(
  parameter int unsigned NUM_ALIAS = 3
) (
  input  logic [7:0] addr,
  output reg_kind_e  kind
);
  always_comb begin
    kind = K_NONE;
    if (addr == OFF_TYPE) kind = K_TYPE;
    if (addr == OFF_CTRL) kind = K_CTRL;
    if (addr == OFF_PTR)  kind = K_PTR;
    for (int a = 0; a <= int'(NUM_ALIAS); a++) begin
      if (addr == 8'(int'(OFF_BASE) + a * int'(ALIAS_STEP)))     kind = K_BASE;
      if (addr == 8'(int'(OFF_BASE) + a * int'(ALIAS_STEP) + 4)) kind = K_ATTR;
    end
  end
endmodule

// File: rtl/mpu_region_store.sv
module mpu_region_store
  import mpu_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              base_we,
  input  logic              attr_we,
  input  logic [31:0]       wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [15:0]       rd_size,
  output logic [15:0]       rd_acc
);
  logic [BASE_W-1:0] base_q [NUM_REGIONS];
  logic [15:0]       size_q [NUM_REGIONS];
  logic [15:0]       acc_q  [NUM_REGIONS];

  for (genvar r = 0; r < int'(NUM_REGIONS); r++) begin : g_region
    logic hit;
    logic base_en, attr_en;
    logic [BASE_W-1:0] base_d;
    logic [15:0] size_d, acc_d;

    always_comb begin
      hit     = (wr_idx == IDX_W'(r));
      base_en = hit && base_we;
      attr_en = hit && attr_we;
      base_d  = wdata[31:32-BASE_W];
      size_d  = wdata[15:0]  & SIZE_MASK;
      acc_d   = wdata[31:16] & ACC_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[r] <= '0;
        size_q[r] <= '0;
        acc_q[r]  <= '0;
      end else begin
        if (base_en) base_q[r] <= base_d;
        if (attr_en) begin
          size_q[r] <= size_d;
          acc_q[r]  <= acc_d;
        end
      end
    end
  end

  always_comb begin
    rd_base = '0;
    rd_size = '0;
    rd_acc  = '0;
    for (int r = 0; r < int'(NUM_REGIONS); r++) begin
      if (rd_idx == IDX_W'(r)) begin
        rd_base = base_q[r];
        rd_size = size_q[r];
        rd_acc  = acc_q[r];
      end
    end
  end
endmodule

// File: rtl/mpu_read_mux.sv
module mpu_read_mux
  import mpu_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  reg_kind_e         kind,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [IDX_W-1:0]  ptr,
  input  logic              ptr_ok,
  input  logic [BASE_W-1:0] base,
  input  logic [15:0]       size,
  input  logic [15:0]       acc,
  output logic [31:0]       rdata
);
  localparam logic [31:0] TYPE_WORD = 32'(NUM_REGIONS) << 8;

  always_comb begin
    rdata = '0;
    unique case (kind)
      K_TYPE:  rdata = TYPE_WORD;
      K_CTRL:  rdata = 32'(ctrl);
      K_PTR:   rdata = 32'(ptr);
      K_BASE:  if (ptr_ok) rdata = {base, 1'b0, ptr};
      K_ATTR:  if (ptr_ok) rdata = {acc, size};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
  import mpu_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_ALIAS   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        prot_enable,
  output logic        prot_fault_bypass,
  output logic        prot_default_map,
  output logic        cfg_invalidate,
  output logic        cfg_warn
);
  localparam logic [IDX_W:0] COUNT = (IDX_W+1)'(NUM_REGIONS);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  reg_kind_e kind;
  mpu_addr_decode #(.NUM_ALIAS(NUM_ALIAS)) u_dec (
    .addr (bus_addr),
    .kind (kind)
  );

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d, tgt_idx;
  logic              ctrl_en, ptr_en;
  logic              ptr_ok, sel_flag, tgt_ok;
  logic              base_we, attr_we;
  logic              inval_d, warn_d, inval_q, warn_q;

  always_comb begin
    ptr_ok   = ({1'b0, ptr_q} < COUNT);
    sel_flag = bus_wdata[SEL_BIT];
    tgt_idx  = sel_flag ? bus_wdata[IDX_W-1:0] : ptr_q;
    tgt_ok   = sel_flag ? ({1'b0, bus_wdata[IDX_W-1:0]} < COUNT) : ptr_ok;

    base_we  = bus_wr && (kind == K_BASE) && tgt_ok;
    attr_we  = bus_wr && (kind == K_ATTR) && ptr_ok;
    ctrl_en  = bus_wr && (kind == K_CTRL);
    ctrl_d   = bus_wdata[CTRL_W-1:0];

    ptr_en   = 1'b0;
    ptr_d    = ptr_q;
    if (bus_wr && (kind == K_PTR) && (bus_wdata < 32'(NUM_REGIONS))) begin
      ptr_en = 1'b1;
      ptr_d  = bus_wdata[IDX_W-1:0];
    end
    if (base_we && sel_flag) begin
      ptr_en = 1'b1;
      ptr_d  = bus_wdata[IDX_W-1:0];
    end

    inval_d = ctrl_en || base_we || attr_we;
    warn_d  = ctrl_en && bus_wdata[CB_BYPASS] && !bus_wdata[CB_EN];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      ptr_q   <= '0;
      inval_q <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      inval_q <= inval_d;
      warn_q  <= warn_d;
    end
  end

  logic [BASE_W-1:0] rd_base;
  logic [15:0]       rd_size, rd_acc;

  mpu_region_store #(.NUM_REGIONS(NUM_REGIONS)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_idx  (sel_flag && (kind == K_BASE) ? tgt_idx : ptr_q),
    .base_we (base_we),
    .attr_we (attr_we),
    .wdata   (bus_wdata),
    .rd_idx  (ptr_q),
    .rd_base (rd_base),
    .rd_size (rd_size),
    .rd_acc  (rd_acc)
  );

  mpu_read_mux #(.NUM_REGIONS(NUM_REGIONS)) u_rmux (
    .kind   (kind),
    .ctrl   (ctrl_q),
    .ptr    (ptr_q),
    .ptr_ok (ptr_ok),
    .base   (rd_base),
    .size   (rd_size),
    .acc    (rd_acc),
    .rdata  (bus_rdata)
  );

  assign prot_enable       = ctrl_q[CB_EN];
  assign prot_fault_bypass = ctrl_q[CB_BYPASS];
  assign prot_default_map  = ctrl_q[CB_DEFMAP];
  assign cfg_invalidate    = inval_q;
  assign cfg_warn          = warn_q;
endmodule

// File: rtl/mpu_regbank_chk.sv
module mpu_regbank_chk #(
  parameter int unsigned NUM_REGIONS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        prot_enable,
  input logic        prot_fault_bypass,
  input logic        prot_default_map,
  input logic        cfg_invalidate,
  input logic        cfg_warn
);
  AST_TYPE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h00) |-> (bus_rdata == (32'(NUM_REGIONS) << 8))); // R2

  AST_CTRL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h04) |-> (bus_rdata[31:3] == '0)); // R3

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({prot_enable, prot_fault_bypass, prot_default_map})); // R3

  AST_WARN_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_warn |-> $past(bus_wr && bus_addr == 8'h04)); // R4

  AST_WARN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_warn |-> (prot_fault_bypass && !prot_enable)); // R4

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h08) |-> (bus_rdata < 32'(NUM_REGIONS))); // R5

  AST_INVAL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalidate |-> $past(bus_wr)); // R11

  AST_WARN_WITH_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_warn |-> cfg_invalidate); // R11
endmodule

bind mpu_regbank mpu_regbank_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .bus_addr          (bus_addr),
  .bus_wr            (bus_wr),
  .bus_wdata         (bus_wdata),
  .bus_rdata         (bus_rdata),
  .prot_enable       (prot_enable),
  .prot_fault_bypass (prot_fault_bypass),
  .prot_default_map  (prot_default_map),
  .cfg_invalidate    (cfg_invalidate),
  .cfg_warn          (cfg_warn)
);

// File: tb/tb_mpu_regbank.sv
module tb_mpu_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        prot_enable, prot_fault_bypass, prot_default_map;
  logic        cfg_invalidate, cfg_warn;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mpu_regbank #(.NUM_REGIONS(8), .NUM_ALIAS(3)) dut (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .prot_enable, .prot_fault_bypass, .prot_default_map,
    .cfg_invalidate, .cfg_warn
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        inv;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0000_0800, 1'b0},  // R2 type word
    '{1'b1, 8'h00, 32'h0000_FFFF, 1'b0},  // R2 store ignored, R11 no pulse
    '{1'b0, 8'h00, 32'h0000_0800, 1'b0},  // R2
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 1'b1},  // R3 R11
    '{1'b0, 8'h04, 32'h0000_0007, 1'b0},  // R3 only three bits
    '{1'b1, 8'h08, 32'h0000_0003, 1'b0},  // R5 R11 pointer store no pulse
    '{1'b0, 8'h08, 32'h0000_0003, 1'b0},  // R5
    '{1'b1, 8'h08, 32'h0000_0008, 1'b0},  // R5 out of range ignored
    '{1'b0, 8'h08, 32'h0000_0003, 1'b0},  // R5
    '{1'b1, 8'h0C, 32'h1234_567F, 1'b0},  // R8 select index 15 discarded
    '{1'b0, 8'h08, 32'h0000_0003, 1'b0},  // R8 pointer kept
    '{1'b0, 8'h0C, 32'h0000_0003, 1'b0},  // R8 base kept
    '{1'b1, 8'h0C, 32'hABCD_E0EF, 1'b1},  // R6 bit4 clear, region 3
    '{1'b0, 8'h0C, 32'hABCD_E0E3, 1'b0},  // R6 low bits cleared, pointer in [3:0]
    '{1'b1, 8'h0C, 32'h0000_1015, 1'b1},  // R7 select region 5
    '{1'b0, 8'h08, 32'h0000_0005, 1'b0},  // R7 pointer updated
    '{1'b0, 8'h0C, 32'h0000_1005, 1'b0},  // R7
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 1'b1},  // R9
    '{1'b0, 8'h10, 32'h173F_FF3F, 1'b0},  // R9 masks
    '{1'b1, 8'h08, 32'h0000_0003, 1'b0},  // R12 back to region 3
    '{1'b0, 8'h0C, 32'hABCD_E0E3, 1'b0},  // R12 base of region 3 intact
    '{1'b0, 8'h10, 32'h0000_0000, 1'b0},  // R12 attr of region 3 untouched
    '{1'b1, 8'h14, 32'h8000_0000, 1'b1},  // R10 alias 1 base
    '{1'b0, 8'h24, 32'h8000_0003, 1'b0},  // R10 alias 3 base
    '{1'b1, 8'h20, 32'h1234_5678, 1'b1},  // R10 alias 2 attr
    '{1'b0, 8'h18, 32'h1234_5638, 1'b0},  // R10 R9 alias 1 attr
    '{1'b0, 8'h28, 32'h1234_5638, 1'b0},  // R10 alias 3 attr
    '{1'b1, 8'h08, 32'h0000_0005, 1'b0},  // R12 region 5
    '{1'b0, 8'h10, 32'h173F_FF3F, 1'b0},  // R12 region 5 attr intact
    '{1'b1, 8'h2C, 32'hFFFF_FFFF, 1'b0},  // R11 unmapped store no pulse
    '{1'b0, 8'h2C, 32'h0000_0000, 1'b0}   // R11 unmapped reads zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #2 d = bus_rdata;
  endtask

  // store taken at the next edge; pulses sampled in the low phase after it
  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    output logic inv, output logic warn);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #2 inv = cfg_invalidate; warn = cfg_warn;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic inv, warn;
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    rd(8'h04, d); check("R1 ctrl", d, 0);
    rd(8'h08, d); check("R1 ptr", d, 0);
    rd(8'h0C, d); check("R1 base", d, 0);
    rd(8'h10, d); check("R1 attr", d, 0);
    check("R1 outputs", {prot_enable, prot_fault_bypass, prot_default_map,
                         cfg_invalidate, cfg_warn}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        wr(VEC[i].addr, VEC[i].data, inv, warn);
        check($sformatf("R11 vector %0d pulse", i), inv, VEC[i].inv);
      end else begin
        rd(VEC[i].addr, d);
        check($sformatf("vector %0d read", i), d, VEC[i].data);
      end
    end

    // R3 control pins
    wr(8'h04, 32'h0000_0005, inv, warn);
    check("R3 pins", {prot_default_map, prot_fault_bypass, prot_enable}, 3'b101);
    check("R4 no warn", warn, 0);

    // R4 warning combination
    wr(8'h04, 32'h0000_0002, inv, warn);
    check("R4 warn raised", warn, 1);
    check("R4 stored", {prot_default_map, prot_fault_bypass, prot_enable}, 3'b010);
    @(negedge clk); #2;
    check("R4 warn one cycle", cfg_warn, 0);
    check("R11 pulse one cycle", cfg_invalidate, 0);
    wr(8'h04, 32'h0000_0003, inv, warn);
    check("R4 enable set no warn", warn, 0);

    // R11 back-to-back stores then drop
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = 32'h0; bus_wr = 1'b1;
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'h0;
    #2 check("R11 first of pair", cfg_invalidate, 1);
    @(negedge clk);
    bus_wr = 1'b0;
    #2 check("R11 second of pair", cfg_invalidate, 1);
    @(negedge clk); #2;
    check("R11 pulse ends", cfg_invalidate, 0);

    // R1 reset clears region state mid-run
    do_reset();
    rd(8'h08, d); check("R1 ptr after reset", d, 0);
    wr(8'h08, 32'h3, inv, warn);
    rd(8'h0C, d); check("R1 region 3 base cleared", d, 32'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule